// File: doc/BRIEF.md
# Chainable Serial Channel-Latch Controller

This block takes an eight-channel on/off word over a three-wire serial link and holds it on registered channel outputs, for example the sink enables of relay coils. The serial clock, data and active-low select come from outside the system clock domain. Each one passes through a two-flop synchronizer, and the edges are detected in the system clock domain. While the select is low, data bits are shifted into a staging register. When the select returns high, the staged word is copied into the output latch in one step.

A serial output carries the staging register's most significant bit, so several controllers can be chained with a shared select. Two active-low global inputs act on both the staging register and the output latch. One forces every channel on. The other forces every channel off and wins over the first.

Top module: `relay_serial_ctrl`

## Requirements
- R1: After system reset, all channel outputs and the serial output are 0.
- R2: While the select is low, each rising serial-clock edge shifts the data input into the staging register's LSB. On the select's rising edge the staging register is copied to the channels. The first bit of an 8-bit frame drives channel bit 7 and the last bit drives channel bit 0.
- R3: While the select is low, the channel outputs keep the value they had before the frame started.
- R4: While the select is high, serial-clock and data activity changes neither the staging register nor the channels. An empty select pulse afterwards latches the unchanged word.
- R5: When a frame has more or fewer than eight clocks, the staging register holds the eight most recently shifted bits. Older content moves up by the number of bits shifted.
- R6: The serial output takes the staging register's MSB on each falling serial-clock edge and on the select's rising edge. After the falling edge that follows the k-th sampled bit (k counted from 0, k≥7), it equals bit k-7.
- R7: While the set input is low and the clear input is high, the staging register and the channels are all ones and the serial output is 1. Serial activity has no effect during this time. After release, an empty select pulse still latches all ones.
- R8: While the clear input is low, the staging register and the channels are all zeros and the serial output is 0, even when the set input is also low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the serial clock rate |
| rst | input | 1 | Synchronous active-high system reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| cs_n_i | input | 1 | Active-low frame select, asynchronous |
| din_i | input | 1 | Serial data in |
| set_n_i | input | 1 | Active-low force all channels on |
| clr_n_i | input | 1 | Active-low force all channels off, wins over set |
| dout_o | output | 1 | Chain output, staging register MSB |
| chan_o | output | WIDTH | Latched channel enables |

## Verification
The bench builds the block with its defaults: WIDTH of 8 and SYNC_STAGES of 2. It drives the serial clock at 20 system clocks per period, which keeps every edge well clear of the synchronizer latency. The defaults make the 16-bit chain test meaningful, because the output reproduces the input exactly one register length later. Short and long frames, idle clocking with the select high, and overlapping set and clear all run against a bench-side model of both registers.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [1:0] {
    OVR_NONE = 2'd0,
    OVR_SET  = 2'd1,
    OVR_CLR  = 2'd2
  } ovr_e;

  // Clear wins over set.
  function automatic ovr_e ovr_decode(input logic set_n, input logic clr_n);
    if (!clr_n) return OVR_CLR;
    if (!set_n) return OVR_SET;
    return OVR_NONE;
  endfunction
endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= INIT;
    else     stg[0] <= d_i;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[k] <= INIT;
      else     stg[k] <= stg[k-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/rsc_edge.sv
module rsc_edge #(
  parameter int WIDTH = 2,
  parameter logic [WIDTH-1:0] IDLE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= IDLE;
    else     prev <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev;
  assign fall_o = ~lvl_i & prev;
endmodule

// File: rtl/rsc_shift.sv
module rsc_shift
  import rsc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ovr_e             ovr_i,
  input  logic             sel_i,
  input  logic             smp_i,
  input  logic             fall_i,
  input  logic             load_i,
  input  logic             din_i,
  output logic [WIDTH-1:0] word_o,
  output logic             dout_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      dout_o <= 1'b0;
    end else begin
      case (ovr_i)
        OVR_CLR: begin
          sh     <= '0;
          dout_o <= 1'b0;
        end
        OVR_SET: begin
          sh     <= '1;
          dout_o <= 1'b1;
        end
        default: begin
          if (sel_i && smp_i) sh <= {sh[MSB-1:0], din_i};
          if (fall_i || load_i) dout_o <= sh[MSB];
        end
      endcase
    end
  end

  assign word_o = sh;

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_i && ovr_i == OVR_NONE) |=> $stable(word_o));
  // R6
  dout_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!fall_i && !load_i && ovr_i == OVR_NONE) |=> $stable(dout_o));
  // R8
  shift_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr_i == OVR_CLR) |=> (word_o == '0 && !dout_o));
endmodule

// File: rtl/rsc_latch.sv
module rsc_latch
  import rsc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ovr_e             ovr_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] word_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)                    q_o <= '0;
    else if (ovr_i == OVR_CLR)  q_o <= '0;
    else if (ovr_i == OVR_SET)  q_o <= '1;
    else if (load_i)            q_o <= word_i;
  end

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && ovr_i == OVR_NONE) |=> $stable(q_o));
  // R7
  force_on_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr_i == OVR_SET) |=> (q_o == '1));
  // R8
  force_off_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr_i == OVR_CLR) |=> (q_o == '0));
endmodule

// File: rtl/relay_serial_ctrl.sv
module relay_serial_ctrl
  import rsc_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_i,
  input  logic             cs_n_i,
  input  logic             din_i,
  input  logic             set_n_i,
  input  logic             clr_n_i,
  output logic             dout_o,
  output logic [WIDTH-1:0] chan_o
);
  // synchronized bundle order: clr_n, set_n, cs_n, sclk, din
  localparam int NSYNC = 5;
  localparam logic [NSYNC-1:0] SYNC_INIT = 5'b11100;

  logic [NSYNC-1:0] s_bus;
  logic             s_clr_n, s_set_n, s_cs_n, s_sclk, s_din;
  logic [1:0]       edg_rise, edg_fall;
  logic             unused_cs_fall;
  ovr_e             ovr;
  logic [WIDTH-1:0] stage_word;

  rsc_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES), .INIT(SYNC_INIT)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({clr_n_i, set_n_i, cs_n_i, sclk_i, din_i}),
    .q_o (s_bus)
  );

  assign {s_clr_n, s_set_n, s_cs_n, s_sclk, s_din} = s_bus;

  // bit 1: cs_n, bit 0: sclk
  rsc_edge #(.WIDTH(2), .IDLE(2'b10)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  ({s_cs_n, s_sclk}),
    .rise_o (edg_rise),
    .fall_o (edg_fall)
  );

  assign unused_cs_fall = edg_fall[1];
  assign ovr = ovr_decode(s_set_n, s_clr_n);

  rsc_shift #(.WIDTH(WIDTH)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .ovr_i  (ovr),
    .sel_i  (!s_cs_n),
    .smp_i  (edg_rise[0]),
    .fall_i (edg_fall[0]),
    .load_i (edg_rise[1]),
    .din_i  (s_din),
    .word_o (stage_word),
    .dout_o (dout_o)
  );

  rsc_latch #(.WIDTH(WIDTH)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .ovr_i  (ovr),
    .load_i (edg_rise[1]),
    .word_i (stage_word),
    .q_o    (chan_o)
  );

  // R2
  latch_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (edg_rise[1] && ovr == OVR_NONE) |=> (chan_o == $past(stage_word)));
endmodule

// File: tb/sim_relay_serial_ctrl.sv
module sim_relay_serial_ctrl;
  localparam int W = 8;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, din = 1'b0, set_n = 1'b1, clr_n = 1'b1;
  logic dout;
  logic [W-1:0] chan;

  always #4 clk = ~clk;

  relay_serial_ctrl #(.WIDTH(W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .sclk_i(sclk), .cs_n_i(cs_n), .din_i(din),
    .set_n_i(set_n), .clr_n_i(clr_n), .dout_o(dout), .chan_o(chan)
  );

  typedef struct {
    logic [W-1:0] chan;
    logic         dout;
    string        tag;
  } item_t;

  item_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [W-1:0] m_sh = '0, m_lat = '0;
  logic m_dout = 1'b0;

  // monitor: compares queued expectations against the ports
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_cmp++;
        if (chan !== it.chan || dout !== it.dout) begin
          n_bad++;
          $display("FAIL %s: chan=%h dout=%b expected chan=%h dout=%b",
                   it.tag, chan, dout, it.chan, it.dout);
        end
      end
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input string tag);
    item_t it;
    wclk(8);
    it.chan = m_lat; it.dout = m_dout; it.tag = tag;
    q.push_back(it);
    wclk(2);
  endtask

  task automatic clock_bit(input logic b, input bit model);
    din = b;
    wclk(HALF);
    sclk = 1'b1;
    wclk(HALF);
    sclk = 1'b0;
    if (model) begin
      m_sh = {m_sh[W-2:0], b};
      m_dout = m_sh[W-1];
    end
  endtask

  task automatic cs_low();
    cs_n = 1'b0; wclk(HALF);
  endtask

  task automatic cs_high(input bit model);
    wclk(HALF);
    cs_n = 1'b1;
    if (model) begin
      m_lat = m_sh;
      m_dout = m_sh[W-1];
    end
    wclk(HALF);
  endtask

  task automatic frame(input logic [31:0] bits, input int n, input string tag);
    cs_low();
    for (int i = 0; i < n; i++) clock_bit(bits[n-1-i], 1'b1);
    cs_high(1'b1);
    push(tag);
  endtask

  initial begin
    logic [15:0] chain;
    wclk(5);
    rst = 1'b0;
    push("R1 reset state");

    frame(32'hA5, 8, "R2 frame A5");
    frame(32'h01, 8, "R2 last bit to channel bit 0");
    frame(32'h80, 8, "R2 first bit to channel bit 7");
    frame(32'h3C, 8, "R2 frame 3C");

    // R3: outputs hold mid-frame
    cs_low();
    for (int i = 0; i < 4; i++) clock_bit(1'b1, 1'b1);
    push("R3 hold during shifting");
    for (int i = 0; i < 4; i++) clock_bit(1'b0, 1'b1);
    push("R3 hold before select rise");
    cs_high(1'b1);
    push("R3 latched after select rise");

    // R4: activity with select high is ignored
    for (int i = 0; i < 5; i++) clock_bit(i[0], 1'b0);
    push("R4 idle clocks leave outputs");
    cs_low(); cs_high(1'b1);
    push("R4 empty frame keeps staging word");

    // R5: long and short frames
    frame(32'hF0F, 12, "R5 twelve bits keep last eight");
    frame(32'h5, 3, "R5 three bits shift old content");

    // R6: chain output reproduces input eight bits later
    chain = 16'hC36A;
    cs_low();
    for (int k = 0; k < 16; k++) begin
      clock_bit(chain[15-k], 1'b1);
      if (k >= 7) begin
        m_dout = chain[15-(k-7)];
        push("R6 chain output delay");
      end
    end
    cs_high(1'b1);
    push("R6 output shows captured first bit");

    // R7: set forces all ones and blocks shifting
    set_n = 1'b0;
    m_sh = '1; m_lat = '1; m_dout = 1'b1;
    push("R7 set forces on");
    cs_low();
    for (int i = 0; i < 3; i++) clock_bit(1'b0, 1'b0);
    cs_high(1'b0);
    push("R7 set overrides serial");
    set_n = 1'b1;
    wclk(6);
    cs_low(); cs_high(1'b1);
    push("R7 staging all ones after release");

    // R8: clear wins over set
    frame(32'h96, 8, "R2 frame before clear");
    set_n = 1'b0; clr_n = 1'b0;
    m_sh = '0; m_lat = '0; m_dout = 1'b0;
    push("R8 clear wins over set");
    set_n = 1'b1;
    push("R8 clear alone");
    clr_n = 1'b1;
    wclk(6);
    cs_low(); cs_high(1'b1);
    push("R8 staging zeros after release");

    wclk(20);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule